// File: doc/BRIEF.md
# Saturating Up/Down Wiper Position Controller

This block is the digital heart of a 128-step digitally controlled resistor. It runs on a fast system clock. It watches three slow external pins: an active-low select, a step strobe and a direction pin. Each falling edge of the step strobe, accepted while the select is low, moves a 7-bit wiper code one position up or down. The code stops at both ends of its range and does not wrap.

The code is decoded into a one-hot tap select that drives the switches of the resistor string. Every pin passes through a two-flop synchronizer, and the select and direction pins are used with the same delay as the strobe. A host therefore only has to meet ordinary setup and hold times around the strobe's falling edge. After reset the wiper sits at midscale, so the resistances to the two ends are about equal. All pins are plain control pins with no handshake: a step that arrives is either applied or dropped at a bound, and nothing is ever held back.

Top module: `wiper_ctrl_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the code is 0x40 and the tap select has only bit 64 set.
- R2: A falling edge on the step strobe, seen while select is low and direction is high (1), raises the code by exactly one.
- R3: A falling edge on the step strobe, seen while select is low and direction is low (0), lowers the code by exactly one.
- R4: While the synchronized select is high (1), the code holds whatever the strobe and direction pins do.
- R5: At code 0x7F an up step leaves the code at 0x7F. It never wraps to 0x00.
- R6: At code 0x00 a down step leaves the code at 0x00. It never wraps to 0x7F.
- R7: A rising edge of the strobe, or a strobe held at either level, leaves the code unchanged.
- R8: In every cycle the tap select has exactly one bit set, and that bit's index equals the code output in the same cycle.
- R9: The strobe level sampled low at clock edge k (after a high sample at edge k-1) changes the code at edge k+2, and not before.
- R10: Select and direction are taken from samples at the same clock edge as the strobe's low sample. A select that rises at the same edge as the strobe falls suppresses the step, and a direction that changes at that edge governs it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_pin | input | 1 | External select, active low, asynchronous |
| step_pin | input | 1 | External step strobe; falling edges move the wiper |
| up_pin | input | 1 | External direction: 1 steps up, 0 steps down |
| code_o | output | 7 | Current wiper code |
| tap_sel_o | output | 128 | One-hot tap select, bit index equals code |

## Verification
Two functions can apply in the same cycle: an accepted strobe edge and the clamp at a range end. The bench drives many more up steps than are needed to reach 0x7F, then many more down steps than are needed to reach 0x00, so edges land while the code already sits on a bound. The behavioural model, which applies the clamp on its own, is compared with the code and the tap select on every clock. A second pairing arises when the select or direction pin changes at the same clock edge as the strobe falls. The bench provokes this directly and judges it against R10, checking that the step is dropped or follows the new direction.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  // Synchronized pin bundle, carried together through the front end
  typedef struct packed {
    logic sel_n;
    logic step;
    logic up;
  } pin_bundle_t;

  localparam int unsigned PIN_COUNT = 3;
  // Idle levels: deselected, strobe high, direction down
  localparam pin_bundle_t PIN_IDLE = '{sel_n: 1'b1, step: 1'b1, up: 1'b0};

  function automatic int unsigned midscale(input int unsigned bits);
    return 32'd1 << (bits - 1);
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fall_detect.sv
module fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic fell
);
  logic last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= level;
  end

  assign fell = last_q & ~level;
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int unsigned WIDTH   = 7,
  parameter int unsigned RST_VAL = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             up,
  output logic [WIDTH-1:0] value
);
  localparam logic [WIDTH-1:0] TOP  = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] BASE = '0;
  localparam logic [WIDTH-1:0] INIT = WIDTH'(RST_VAL);

  logic at_top, at_base;
  assign at_top  = (value == TOP);
  assign at_base = (value == BASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= INIT;
    end else if (adv) begin
      if (up && !at_top)       value <= value + 1'b1;
      else if (!up && !at_base) value <= value - 1'b1;
    end
  end
endmodule

// File: rtl/tap_decoder.sv
module tap_decoder #(
  parameter int unsigned WIDTH = 7,
  localparam int unsigned TAPS = 1 << WIDTH
) (
  input  logic [WIDTH-1:0] code,
  output logic [TAPS-1:0]  taps
);
  generate
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
      assign taps[t] = (code == WIDTH'(t));
    end
  endgenerate
endmodule

// File: rtl/wiper_ctrl_top.sv
module wiper_ctrl_top #(
  parameter int unsigned CODE_W      = 7,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned TAP_COUNT  = 1 << CODE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel_n_pin,
  input  logic                 step_pin,
  input  logic                 up_pin,
  output logic [CODE_W-1:0]    code_o,
  output logic [TAP_COUNT-1:0] tap_sel_o
);
  import wiper_pkg::*;

  localparam logic [PIN_COUNT-1:0] IDLE_BITS = PIN_IDLE;

  pin_bundle_t raw_pins, sync_pins;
  logic [PIN_COUNT-1:0] raw_bits, sync_bits;

  assign raw_pins = '{sel_n: sel_n_pin, step: step_pin, up: up_pin};
  assign raw_bits = raw_pins;

  generate
    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_sync
      pin_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (IDLE_BITS[p])
      ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_bits[p]),
        .q     (sync_bits[p])
      );
    end
  endgenerate

  assign sync_pins = sync_bits;

  logic sel_n_s, up_s, step_fall, step_go;
  assign sel_n_s = sync_pins.sel_n;
  assign up_s    = sync_pins.up;

  fall_detect u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (sync_pins.step),
    .fell  (step_fall)
  );

  assign step_go = step_fall & ~sel_n_s;

  sat_counter #(
    .WIDTH   (CODE_W),
    .RST_VAL (midscale(CODE_W))
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (step_go),
    .up    (up_s),
    .value (code_o)
  );

  tap_decoder #(
    .WIDTH (CODE_W)
  ) u_dec (
    .code (code_o),
    .taps (tap_sel_o)
  );
endmodule

// File: rtl/wiper_ctrl_chk.sv
module wiper_ctrl_chk #(
  parameter int unsigned CODE_W = 7,
  localparam int unsigned TAPS  = 1 << CODE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] code,
  input logic [TAPS-1:0]   tap,
  input logic              sel_n_s,
  input logic              step_fall
);
  localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] BOT = '0;

  // R2 R3
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code != $past(code) |->
      (code == CODE_W'($past(code) + 1'b1)) || (code == CODE_W'($past(code) - 1'b1)));

  // R4
  hold_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n_s |=> $stable(code));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code == TOP |=> code != BOT);

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code == BOT |=> code != TOP);

  // R7
  fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_fall |=> $stable(code));

  // R8
  tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(tap) == 1) && tap[code]);
endmodule

bind wiper_ctrl_top wiper_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .code      (code_o),
  .tap       (tap_sel_o),
  .sel_n_s   (sel_n_s),
  .step_fall (step_fall)
);

// File: tb/tb_wiper_ctrl_top.sv
`timescale 1ns/1ps
module tb_wiper_ctrl_top;
  localparam int W = 7;
  localparam int N = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n_pin = 1'b1, step_pin = 1'b1, up_pin = 1'b0;
  logic [W-1:0] code_o;
  logic [N-1:0] tap_sel_o;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wiper_ctrl_top dut (
    .clk(clk), .rst_n(rst_n), .sel_n_pin(sel_n_pin), .step_pin(step_pin),
    .up_pin(up_pin), .code_o(code_o), .tap_sel_o(tap_sel_o)
  );

  // Behavioural reference: history of pin samples, one per clock
  typedef struct { bit sel_n; bit step; bit up; } smp_t;
  smp_t hist[$];
  int m_code = 64;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      for (int i = 0; i < 3; i++) hist.push_back('{1'b1, 1'b1, 1'b0});
      m_code = 64;
    end else begin
      hist.push_back('{sel_n_pin, step_pin, up_pin});
      if (hist.size() > 4) void'(hist.pop_front());
      // hist[0]: three edges back, hist[1]: two edges back
      if (hist[0].step && !hist[1].step && !hist[1].sel_n) begin
        if (hist[1].up) m_code = (m_code < N - 1) ? m_code + 1 : m_code;
        else            m_code = (m_code > 0) ? m_code - 1 : m_code;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Per-cycle comparison with the model (R2 R3 R5 R6 R8)
  always @(negedge clk) begin
    if (!done) begin
      check("R2 R3 R5 R6 model code", int'(code_o), m_code);
      checks++;
      if (tap_sel_o !== (N'(1) << m_code)) begin
        errors++;
        $display("FAIL R8: actual tap=%h expected tap=%h", tap_sel_o, N'(1) << m_code);
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(bit up);
    up_pin = up; sel_n_pin = 1'b0;
    wait_cyc(3);
    step_pin = 1'b0; wait_cyc(4);
    step_pin = 1'b1; wait_cyc(4);
  endtask

  initial begin
    wait_cyc(5);
    check("R1 reset code", int'(code_o), 64);
    check("R1 reset tap", int'(tap_sel_o[64]), 1);
    rst_n = 1'b1;
    wait_cyc(1);
    check("R1 first cycle code", int'(code_o), 64);

    // R9 latency: strobe low sampled at edge k, code moves at edge k+2
    up_pin = 1'b1; sel_n_pin = 1'b0; wait_cyc(3);
    step_pin = 1'b0;
    wait_cyc(1); check("R9 edge k", int'(code_o), 64);
    wait_cyc(1); check("R9 edge k+1", int'(code_o), 64);
    wait_cyc(1); check("R9 edge k+2", int'(code_o), 65);
    // R7 held low, then rising edge: no change
    wait_cyc(6); check("R7 held low", int'(code_o), 65);
    step_pin = 1'b1; wait_cyc(6);
    check("R7 rising edge", int'(code_o), 65);

    // R2 several up steps
    for (int i = 0; i < 5; i++) pulse(1'b1);
    check("R2 five ups", int'(code_o), 70);
    // R3 down steps
    for (int i = 0; i < 3; i++) pulse(1'b0);
    check("R3 three downs", int'(code_o), 67);

    // R4 select high: strobes ignored
    sel_n_pin = 1'b1; up_pin = 1'b1; wait_cyc(3);
    for (int i = 0; i < 4; i++) begin
      step_pin = 1'b0; wait_cyc(4); step_pin = 1'b1; wait_cyc(4);
    end
    check("R4 deselected hold", int'(code_o), 67);

    // R10 select rises together with strobe fall: dropped
    sel_n_pin = 1'b0; wait_cyc(3);
    sel_n_pin = 1'b1; step_pin = 1'b0; wait_cyc(5);
    step_pin = 1'b1; wait_cyc(4);
    check("R10 select with edge", int'(code_o), 67);
    // R10 direction flips together with strobe fall: new direction used
    sel_n_pin = 1'b0; up_pin = 1'b1; wait_cyc(3);
    up_pin = 1'b0; step_pin = 1'b0; wait_cyc(5);
    step_pin = 1'b1; wait_cyc(4);
    check("R10 direction with edge", int'(code_o), 66);

    // R5 saturate at top
    for (int i = 0; i < 70; i++) pulse(1'b1);
    check("R5 top clamp", int'(code_o), 127);
    check("R8 top tap", int'(tap_sel_o[127]), 1);
    // R6 saturate at bottom
    for (int i = 0; i < 135; i++) pulse(1'b0);
    check("R6 bottom clamp", int'(code_o), 0);
    check("R8 bottom tap", int'(tap_sel_o[0]), 1);
    pulse(1'b1);
    check("R2 up from zero", int'(code_o), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=done", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule